// File: doc/BRIEF.md
# Segmented Spike Bus

A row of core ports shares one spike bus that is cut into segments, one segment per gap between neighbouring ports. Each gap holds a link switch. A closed switch joins the two ports on either side of it, and an open switch separates them. Each unbroken run of closed links forms its own sub-bus. The link pattern is loaded once, while the block is in configuration mode. During traffic the pattern is fixed, so no packet needs a routing decision.

During traffic each port offers a 16-bit spike address with a valid/ready handshake. Within one sub-bus a round-robin arbiter grants one sender per cycle. One cycle after the grant, every other port of that run sees the address with a receive strobe. Runs that do not overlap carry their packets in the same cycle. A per-run busy flag shows which sub-buses moved a packet, so concurrency can be observed.

Top module: `seg_spike_bus`

## Requirements
- R1: After reset all link switches are open, so every port is a sub-bus of its own, and `rx_valid`, `seg_busy` and `tx_ready` are all zero.
- R2: The link pattern `cfg_link` is stored only on a clock edge where `cfg_mode` and `cfg_load` are both high. A `cfg_load` pulse with `cfg_mode` low leaves the stored pattern unchanged.
- R3: While `cfg_mode` is high no port is granted (`tx_ready` all zero) and no packet is delivered. A cycle in configuration mode without `cfg_load` keeps the stored pattern.
- R4: Bit i of the link pattern set to 1 joins port i to port i+1. A granted packet appears on `rx_data` (port q occupies bits q*16 upward), with `rx_valid` high, exactly one cycle after the handshake, at every port of the sender's run and at no port outside it.
- R5: The sender of a packet never receives its own packet.
- R6: Runs that do not overlap each grant a sender in the same cycle.
- R7: Within a run, arbitration is round-robin over port indices. The search starts at the port after the last granted port of that run and wraps around. A fresh pointer gives the lowest-indexed requesting port the grant.
- R8: `tx_ready` is high only for a port whose `tx_valid` is high. A port that loses arbitration and keeps its request is granted within the number of ports in its run.
- R9: `seg_busy[h]` is high in the delivery cycle of a packet on the run whose lowest port is h, and low for all other h.
- R10: Every stored configuration write resets all arbitration pointers, so the lowest requesting port of each run wins next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 1 | Configuration mode; blocks traffic |
| cfg_load | input | 1 | Store `cfg_link` when in configuration mode |
| cfg_link | input | NPORTS-1 | Link switch pattern, bit i joins port i and i+1 |
| tx_valid | input | NPORTS | Per-port send request |
| tx_ready | output | NPORTS | Per-port grant; handshake when both high |
| tx_data | input | NPORTS*AW | Per-port spike address, port p at bits p*AW |
| rx_valid | output | NPORTS | Per-port receive strobe |
| rx_data | output | NPORTS*AW | Per-port received spike address |
| seg_busy | output | NPORTS | Per-run transfer flag, indexed by the run's lowest port |

## Verification
A four-port instance is swept over every link pattern combined with every request pattern. Each pattern is loaded fresh, so the predicted winner of each run is its lowest requester. This sweep separates wrong run boundaries, a lost concurrent transfer, echo to the sender and misrouted payloads. A held all-port request on one joined run shows the rotation order and the eventual grant of waiting ports. A reload then shows the pointer reset. Separate sequences drive a load pulse outside configuration mode and requests inside it, to show that the first is ignored and that the second blocks traffic.

// File: rtl/seg_spike_bus.sv
module seg_spike_bus #(
  parameter int NPORTS = 8,
  parameter int AW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_mode,
  input  logic                 cfg_load,
  input  logic [NPORTS-2:0]    cfg_link,
  input  logic [NPORTS-1:0]    tx_valid,
  output logic [NPORTS-1:0]    tx_ready,
  input  logic [NPORTS*AW-1:0] tx_data,
  output logic [NPORTS-1:0]    rx_valid,
  output logic [NPORTS*AW-1:0] rx_data,
  output logic [NPORTS-1:0]    seg_busy
);
  localparam int IW = (NPORTS > 1) ? $clog2(NPORTS) : 1;

  logic [NPORTS-2:0] link_q;
  logic [IW-1:0]     head [NPORTS];
  logic [IW-1:0]     last [NPORTS];
  logic [IW-1:0]     src  [NPORTS];
  logic [AW-1:0]     run_data [NPORTS];
  logic [NPORTS-1:0] gnt, run_hit;
  logic              cfg_wr;

  assign cfg_wr   = cfg_mode && cfg_load;
  assign tx_ready = gnt;

  always_ff @(posedge clk) begin
    if (!rst_n)      link_q <= '0;
    else if (cfg_wr) link_q <= cfg_link;
  end

  always_comb begin
    for (int p = 0; p < NPORTS; p++) begin
      int h;
      h = p;
      for (int j = NPORTS - 2; j >= 0; j--)
        if (j < p && h == j + 1 && link_q[j]) h = j;
      head[p] = IW'(h);
    end
  end

  always_comb begin
    gnt = '0;
    run_hit = '0;
    for (int h = 0; h < NPORTS; h++) src[h] = '0;
    for (int h = 0; h < NPORTS; h++) begin
      for (int k = 1; k <= NPORTS; k++) begin
        int idx;
        idx = (int'(last[h]) + k) % NPORTS;
        if (!run_hit[h] && !cfg_mode && tx_valid[idx] && head[idx] == IW'(h)) begin
          gnt[idx]   = 1'b1;
          run_hit[h] = 1'b1;
          src[h]     = IW'(idx);
        end
      end
    end
  end

  always_comb begin
    for (int h = 0; h < NPORTS; h++)
      run_data[h] = tx_data[int'(src[h])*AW +: AW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || cfg_wr) begin
      for (int h = 0; h < NPORTS; h++) last[h] <= IW'(NPORTS - 1);
    end else begin
      for (int h = 0; h < NPORTS; h++)
        if (run_hit[h]) last[h] <= src[h];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_valid <= '0;
      rx_data  <= '0;
      seg_busy <= '0;
    end else begin
      seg_busy <= run_hit;
      for (int q = 0; q < NPORTS; q++) begin
        rx_valid[q] <= run_hit[head[q]] && (src[head[q]] != IW'(q));
        if (run_hit[head[q]] && (src[head[q]] != IW'(q)))
          rx_data[q*AW +: AW] <= run_data[head[q]];
      end
    end
  end

  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_mode && cfg_load) |=> $stable(link_q));

  p_cfg_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mode |-> (tx_ready == '0));

  p_ready_needs_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready & ~tx_valid) == '0);

  p_busy_after_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|seg_busy) |-> $past(|tx_ready));

  p_rx_needs_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|rx_valid) |-> (|seg_busy));

  for (genvar p = 0; p < NPORTS; p++) begin : g_chk
    p_no_self_rx_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid[p] && tx_ready[p]) |=> !rx_valid[p]);
  end
endmodule

// File: tb/seg_spike_bus_tb.sv
module seg_spike_bus_tb_top;
  localparam int N = 4;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst_n, cfg_mode, cfg_load;
  logic [N-2:0] cfg_link;
  logic [N-1:0] tx_valid, tx_ready, rx_valid, seg_busy;
  logic [N*AW-1:0] tx_data, rx_data;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  seg_spike_bus #(.NPORTS(N), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_load(cfg_load),
    .cfg_link(cfg_link), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_data(rx_data), .seg_busy(seg_busy));

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic load_cfg(input logic [N-2:0] c);
    cfg_mode = 1'b1; cfg_load = 1'b1; cfg_link = c;
    tick();
    cfg_mode = 1'b0; cfg_load = 1'b0;
  endtask

  function automatic logic [AW-1:0] pdata(input int c, input int v, input int p);
    return AW'(16'h8000 + c * 256 + v * 16 + p);
  endfunction

  function automatic void model(input int c, input int v, output logic [N-1:0] g,
                                output logic [N-1:0] rv, output logic [N*AW-1:0] rd,
                                output logic [N-1:0] bb);
    int hd [N];
    g = '0; rv = '0; rd = '0; bb = '0;
    for (int p = 0; p < N; p++) hd[p] = (p > 0 && c[p-1]) ? hd[p-1] : p;
    for (int p = 0; p < N; p++) begin
      logic taken;
      taken = 1'b0;
      for (int q = 0; q < p; q++) if (v[q] && hd[q] == hd[p]) taken = 1'b1;
      if (v[p] && !taken) g[p] = 1'b1;
    end
    for (int s = 0; s < N; s++) if (g[s]) begin
      bb[hd[s]] = 1'b1;
      for (int q = 0; q < N; q++) if (hd[q] == hd[s] && q != s) begin
        rv[q] = 1'b1;
        rd[q*AW +: AW] = pdata(c, v, s);
      end
    end
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_mode = 1'b0; cfg_load = 1'b0; cfg_link = '0;
    tx_valid = '0; tx_data = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk("R1", "rx_valid", 64'(rx_valid), 64'h0);
    chk("R1", "seg_busy", 64'(seg_busy), 64'h0);
    chk("R1", "tx_ready", 64'(tx_ready), 64'h0);
    tx_valid = '1;
    #1 chk("R1", "isolated grants", 64'(tx_ready), 64'hF);
    tick();
    tx_valid = '0;
    chk("R1", "isolated rx", 64'(rx_valid), 64'h0);
    chk("R1", "isolated busy", 64'(seg_busy), 64'hF);

    for (int c = 0; c < (1 << (N-1)); c++) begin
      for (int v = 0; v < (1 << N); v++) begin
        logic [N-1:0] g, rv, bb;
        logic [N*AW-1:0] rd, mask;
        model(c, v, g, rv, rd, bb);
        load_cfg((N-1)'(c));
        for (int p = 0; p < N; p++) tx_data[p*AW +: AW] = pdata(c, v, p);
        tx_valid = N'(v);
        #1 chk("R7", "first grant", 64'(tx_ready), 64'(g));
        if ($countones(bb) > 1) chk("R6", "concurrent grants", 64'($countones(tx_ready)), 64'($countones(bb)));
        tick();
        tx_valid = '0;
        mask = '0;
        for (int q = 0; q < N; q++) if (rv[q]) mask[q*AW +: AW] = '1;
        chk("R4", "rx_valid", 64'(rx_valid), 64'(rv));
        chk("R4", "rx_data", 64'(rx_data & mask), 64'(rd));
        chk("R5", "sender echo", 64'(rx_valid & g), 64'h0);
        chk("R9", "seg_busy", 64'(seg_busy), 64'(bb));
      end
    end

    load_cfg('0);
    cfg_load = 1'b1; cfg_link = '1;
    tick();
    cfg_load = 1'b0;
    tx_valid = 4'b0011;
    #1 chk("R2", "ignored load grants", 64'(tx_ready), 64'h3);
    tick();
    tx_valid = '0;
    chk("R2", "ignored load rx", 64'(rx_valid), 64'h0);

    load_cfg('1);
    cfg_mode = 1'b1;
    tx_valid = '1;
    #1 chk("R3", "no grant in cfg", 64'(tx_ready), 64'h0);
    tick();
    chk("R3", "no rx in cfg", 64'(rx_valid), 64'h0);
    chk("R3", "no busy in cfg", 64'(seg_busy), 64'h0);
    cfg_mode = 1'b0;
    #1;
    for (int i = 0; i < 5; i++) begin
      chk("R7", "rotation", 64'(tx_ready), 64'(1 << (i % N)));
      tick();
    end
    chk("R8", "waiting port served", 64'(rx_valid), 64'hE);
    tx_valid = '0;
    load_cfg('1);
    tx_valid = '1;
    #1 chk("R10", "pointer reset", 64'(tx_ready), 64'h1);
    tick();
    tx_valid = '0;
    tick();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule